// File: doc/BRIEF.md
# DMA Bus Master Cycle Sequencer

This block runs the local-memory bus cycles that move one burst of words between a FIFO and buffer memory. When the FIFO side posts a service request with a nonzero word count, the block raises a bus request and waits for the bus grant. Once the grant arrives it owns the bus and runs one cycle per word through the phases t1, t2, t3, any number of wait phases tw, and t4. It drives an active-low read strobe or write strobe, increments the word address, and hands each word to or from the FIFO in t4. After the last word it drops the request. It lets go of the bus when the grant is removed.

The master strobes leave the block with an output enable, and a pad ring turns them into three-state pins. One extra pin has two roles, chosen by a configuration bit that is written through a small configuration port. In long-address mode the pin is an address strobe. It pulses once per bus tenure, before the first t1, while the fixed upper address half is on the address bus, so that external latches can capture it. In port mode the pin passes the remote-port request through as an ordinary always-driven output. Until the configuration has been written, the pin is not driven.

Top module: `dma_cycle_seq`

## Requirements
- R1: After reset, bus_req is 0, mst_oe is 0, shr_oe is 0, and both mrd_n and mwr_n are 1.
- R2: A svc_req with a nonzero svc_len, seen while idle, sets bus_req to 1 from the next cycle on. A svc_req with svc_len equal to 0 is ignored, and bus_req stays 0.
- R3: Before bus_grant is 1, no strobe goes low and mst_oe stays 0. A strobe is only low while mst_oe and bus_grant are both 1.
- R4: In a write burst (svc_wr=1), mwr_n is low in t2, t3 and every tw, with wdata_out equal to the FIFO head word. fifo_pop is 1 in the t4 that follows. mrd_n stays 1.
- R5: In a read burst (svc_wr=0), mrd_n is low in t2, t3 and every tw. The rdata_in present in the last low cycle is captured at the clock edge that raises mrd_n. It appears on rd_word with fifo_push=1 in t4.
- R6: ready is looked at only at the end of t3 and of each tw. Each 1 seen there adds one tw, so a word with w wait phases holds its strobe low for exactly 2+w cycles. Values of ready at other times have no effect.
- R7: Word k of a burst (counted from 0) is addressed at svc_addr+k, modulo 2^HALF_W, during its strobe. The burst runs exactly svc_len words.
- R8: With the long-address bit set to 1, shr_pin pulses high for exactly one cycle per tenure, before the first strobe. During that cycle addr_out carries upper_addr. shr_oe is 1 only while mst_oe is 1.
- R9: With the long-address bit set to 0 after configuration, shr_oe is always 1 and shr_pin equals port_req_in.
- R10: Until the first accepted cfg_wr, shr_oe is 0.
- R11: bus_req falls to 0 in the cycle after the last t4. Once bus_grant is removed, mst_oe returns to 0 in the next cycle and the block is idle again.
- R12: A cfg_wr is taken only while idle. A cfg_wr during a burst leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_long_in | input | 1 | Long-address bit value for cfg_wr |
| upper_addr | input | HALF_W | Fixed upper address half |
| svc_req | input | 1 | FIFO service request |
| svc_wr | input | 1 | 1 = write to memory, 0 = read from memory |
| svc_len | input | LEN_W | Words in the burst |
| svc_addr | input | HALF_W | Start word address (lower half) |
| bus_req | output | 1 | Bus request, active high |
| bus_grant | input | 1 | Bus grant, active high |
| ready | input | 1 | 1 at t3/tw inserts a wait phase |
| mst_oe | output | 1 | Output enable for strobes and address |
| mrd_n | output | 1 | Master read strobe, active low |
| mwr_n | output | 1 | Master write strobe, active low |
| addr_out | output | HALF_W | Address bus (upper half during the address-strobe cycle) |
| wr_word | input | DW | FIFO head word for writes |
| wdata_out | output | DW | Write data to memory |
| fifo_pop | output | 1 | Write word consumed |
| rdata_in | input | DW | Read data from memory |
| rd_word | output | DW | Captured read word |
| fifo_push | output | 1 | Read word valid for the FIFO |
| port_req_in | input | 1 | Remote-port request for port mode |
| shr_pin | output | 1 | Shared pin value |
| shr_oe | output | 1 | Shared pin output enable |

## Verification
The assertions check on every cycle that the two strobes never overlap, that a strobe is low only under a grant, and that ready at t3 or tw picks the next phase correctly. They also check that the address-strobe pulse lasts one cycle and that a zero-length request never leaves idle. The bench's scenarios are needed for the rest:
- burst lengths and address sequencing;
- data capture at the strobe's rising edge;
- the exact strobe width for a chosen wait pattern;
- the shared pin's behaviour before configuration, in each mode, and after a configuration write that comes mid-burst.

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq #(
  parameter int HALF_W = 16,
  parameter int DW     = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_long_in,
  input  logic [HALF_W-1:0] upper_addr,
  input  logic              svc_req,
  input  logic              svc_wr,
  input  logic [LEN_W-1:0]  svc_len,
  input  logic [HALF_W-1:0] svc_addr,
  output logic              bus_req,
  input  logic              bus_grant,
  input  logic              ready,
  output logic              mst_oe,
  output logic              mrd_n,
  output logic              mwr_n,
  output logic [HALF_W-1:0] addr_out,
  input  logic [DW-1:0]     wr_word,
  output logic [DW-1:0]     wdata_out,
  output logic              fifo_pop,
  input  logic [DW-1:0]     rdata_in,
  output logic [DW-1:0]     rd_word,
  output logic              fifo_push,
  input  logic              port_req_in,
  output logic              shr_pin,
  output logic              shr_oe
);

  localparam logic [3:0] S_IDLE = 4'd0;
  localparam logic [3:0] S_REQ  = 4'd1;
  localparam logic [3:0] S_ADS  = 4'd2;
  localparam logic [3:0] S_T1   = 4'd3;
  localparam logic [3:0] S_T2   = 4'd4;
  localparam logic [3:0] S_T3   = 4'd5;
  localparam logic [3:0] S_TW   = 4'd6;
  localparam logic [3:0] S_T4   = 4'd7;
  localparam logic [3:0] S_REL  = 4'd8;

  logic [3:0]        st;
  logic              cfg_ok, cfg_long, is_wr;
  logic [LEN_W-1:0]  left;
  logic [HALF_W-1:0] addr_q;
  logic [DW-1:0]     rd_q;

  wire strobe_ph = (st == S_T2) || (st == S_T3) || (st == S_TW);
  wire hold_bus  = (st >= S_ADS);
  wire leave_t3  = ((st == S_T3) || (st == S_TW)) && !ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cfg_ok   <= 1'b0;
      cfg_long <= 1'b0;
      is_wr    <= 1'b0;
      left     <= '0;
      addr_q   <= '0;
      rd_q     <= '0;
    end else begin
      if (leave_t3 && !is_wr) rd_q <= rdata_in;
      case (st)
        S_IDLE: begin
          if (cfg_wr) begin
            cfg_ok   <= 1'b1;
            cfg_long <= cfg_long_in;
          end
          if (svc_req && svc_len != '0) begin
            is_wr  <= svc_wr;
            left   <= svc_len;
            addr_q <= svc_addr;
            st     <= S_REQ;
          end
        end
        S_REQ:  if (bus_grant) st <= cfg_long ? S_ADS : S_T1;
        S_ADS:  st <= S_T1;
        S_T1:   st <= S_T2;
        S_T2:   st <= S_T3;
        S_T3:   st <= ready ? S_TW : S_T4;
        S_TW:   st <= ready ? S_TW : S_T4;
        S_T4: begin
          left   <= left - 1'b1;
          addr_q <= addr_q + 1'b1;
          st     <= (left == 1) ? S_REL : S_T1;
        end
        S_REL:  if (!bus_grant) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign bus_req   = (st != S_IDLE) && (st != S_REL);
  assign mst_oe    = bus_grant && hold_bus;
  assign mrd_n     = !(strobe_ph && !is_wr);
  assign mwr_n     = !(strobe_ph && is_wr);
  assign addr_out  = (st == S_ADS) ? upper_addr : addr_q;
  assign wdata_out = wr_word;
  assign fifo_pop  = (st == S_T4) && is_wr;
  assign fifo_push = (st == S_T4) && !is_wr;
  assign rd_word   = rd_q;
  assign shr_pin   = cfg_long ? (st == S_ADS) : port_req_in;
  assign shr_oe    = cfg_ok && (cfg_long ? mst_oe : 1'b1);

endmodule

// File: rtl/dma_cycle_seq_chk.sv
module dma_cycle_seq_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       st,
  input logic             bus_grant,
  input logic             ready,
  input logic             mrd_n,
  input logic             mwr_n,
  input logic             shr_pin,
  input logic             shr_oe,
  input logic             cfg_long,
  input logic             svc_req,
  input logic [LEN_W-1:0] svc_len
);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mrd_n && !mwr_n)); // R4

  AST_STROBE_UNDER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (!mrd_n || !mwr_n) |-> bus_grant); // R3

  AST_ZERO_LEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd0 && svc_req && svc_len == '0) |=> st == 4'd0); // R2

  AST_WAIT_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == 4'd5 || st == 4'd6) && ready) |=> st == 4'd6); // R6

  AST_END_ON_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == 4'd5 || st == 4'd6) && !ready) |=> st == 4'd7); // R6

  AST_ADS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_long && shr_pin && shr_oe) |=> !shr_pin); // R8

endmodule

bind dma_cycle_seq dma_cycle_seq_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .bus_grant(bus_grant), .ready(ready),
  .mrd_n(mrd_n), .mwr_n(mwr_n), .shr_pin(shr_pin), .shr_oe(shr_oe),
  .cfg_long(cfg_long), .svc_req(svc_req), .svc_len(svc_len)
);

// File: tb/sim_dma_cycle_seq.sv
`timescale 1ns/1ps
module sim_dma_cycle_seq;
  localparam int HW = 16, DW = 16, LW = 8;

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, cfg_long_in = 0;
  logic [HW-1:0] upper_addr = 16'hBEEF;
  logic svc_req = 0, svc_wr = 0;
  logic [LW-1:0] svc_len = 0;
  logic [HW-1:0] svc_addr = 0;
  logic bus_req, bus_grant = 0, ready = 0, mst_oe, mrd_n, mwr_n;
  logic [HW-1:0] addr_out;
  logic [DW-1:0] wr_word = 0, wdata_out, rdata_in, rd_word;
  logic fifo_pop, fifo_push, port_req_in = 0, shr_pin, shr_oe;

  always #2 clk = ~clk;

  dma_cycle_seq #(.HALF_W(HW), .DW(DW), .LEN_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_long_in(cfg_long_in),
    .upper_addr(upper_addr), .svc_req(svc_req), .svc_wr(svc_wr),
    .svc_len(svc_len), .svc_addr(svc_addr), .bus_req(bus_req),
    .bus_grant(bus_grant), .ready(ready), .mst_oe(mst_oe), .mrd_n(mrd_n),
    .mwr_n(mwr_n), .addr_out(addr_out), .wr_word(wr_word),
    .wdata_out(wdata_out), .fifo_pop(fifo_pop), .rdata_in(rdata_in),
    .rd_word(rd_word), .fifo_push(fifo_push), .port_req_in(port_req_in),
    .shr_pin(shr_pin), .shr_oe(shr_oe)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  bit m_cfgd = 0, m_long = 0;
  int wt [0:15];

  function automatic logic [DW-1:0] rpat(input logic [HW-1:0] a);
    return {a[6:0], a[15:7]} ^ 16'h5A3C;
  endfunction
  function automatic logic [DW-1:0] wpat(input int k, input int b);
    return 16'h1000 ^ 16'(k * 16'h0137) ^ 16'(b << 9);
  endfunction

  assign rdata_in = rpat(addr_out);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic cfg(input bit lng);
    @(negedge clk); cfg_wr = 1; cfg_long_in = lng;
    @(negedge clk); cfg_wr = 0;
    m_cfgd = 1; m_long = lng;
  endtask

  task automatic burst(input bit wr, input int len, input logic [HW-1:0] a0,
                       input int wmode, input bit poke, input int bid);
    int k = 0, cnt = 0, ads = 0, seen = 0, guard = 0, gd;
    bit prev_low = 0, low, other;
    for (int i = 0; i < len; i++)
      wt[i] = (wmode == 0) ? int'($urandom % 4) : (wmode == 1 ? 0 : 3);
    wr_word = wpat(0, bid);
    @(negedge clk);
    svc_req = 1; svc_wr = wr; svc_len = LW'(len); svc_addr = a0;
    @(negedge clk);
    svc_req = 0; svc_wr = $urandom; svc_len = $urandom;
    chk(bus_req === 1'b1, "R2 bus_req after request", {31'd0, bus_req}, 1);
    gd = $urandom % 4;
    for (int i = 0; i < gd; i++) begin
      ready = $urandom;
      @(negedge clk);
      chk(!mst_oe && mrd_n && mwr_n && bus_req, "R3 idle before grant",
          {mst_oe, mrd_n, mwr_n, bus_req}, 4'b0111);
    end
    bus_grant = 1;
    while (guard < 400) begin
      @(negedge clk);
      guard++;
      low   = wr ? !mwr_n : !mrd_n;
      other = wr ? !mrd_n : !mwr_n;
      if (other) chk(0, "R4 opposite strobe low", 1, 0);
      if (m_long && shr_oe && shr_pin) begin
        ads++;
        chk(addr_out == upper_addr && seen == 0, "R8 upper address pulse", addr_out, upper_addr);
      end
      if (m_cfgd && !m_long)
        chk(shr_oe && shr_pin == port_req_in, "R9 port mode pin", {shr_oe, shr_pin}, {1'b1, port_req_in});
      if (!m_cfgd) chk(!shr_oe, "R10 pin floats", shr_oe, 0);
      if (m_long && shr_oe) chk(mst_oe, "R8 shared oe tied to tenure", mst_oe, 1);
      if (low) begin
        cnt++; seen++;
        chk(mst_oe && addr_out == HW'(a0 + k), "R7 strobe address", addr_out, HW'(a0 + k));
        if (wr) chk(wdata_out == wpat(k, bid), "R4 write data", wdata_out, wpat(k, bid));
      end else if (prev_low) begin
        chk(cnt == 2 + wt[k], "R6 strobe width", cnt, 2 + wt[k]);
        if (wr) chk(fifo_pop && !fifo_push, "R4 pop in t4", {fifo_pop, fifo_push}, 2'b10);
        else chk(fifo_push && rd_word == rpat(HW'(a0 + k)), "R5 captured read word",
                 rd_word, rpat(HW'(a0 + k)));
        k++; cnt = 0;
        wr_word = wpat(k, bid);
      end
      prev_low = low;
      if (!bus_req) break;
      if (low && cnt >= 2) ready = (cnt - 2) < wt[k];
      else ready = $urandom;
      port_req_in = $urandom;
      cfg_wr = poke && guard == 2;
      cfg_long_in = !m_long;
    end
    cfg_wr = 0;
    chk(k == len, "R7 word count", k, len);
    chk(ads == (m_long ? 1 : 0), "R8 pulses per tenure", ads, m_long);
    chk(!bus_req, "R11 request dropped", bus_req, 0);
    @(negedge clk); bus_grant = 0;
    @(negedge clk);
    chk(!mst_oe && mrd_n && mwr_n && !bus_req, "R11 released", {mst_oe, bus_req}, 0);
    if (m_cfgd) chk(shr_oe == !m_long, m_long ? "R8 pin off after release" : "R12 mode kept",
                    shr_oe, !m_long);
    else chk(!shr_oe, "R10 unconfigured", shr_oe, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk(!bus_req && !mst_oe && !shr_oe && mrd_n && mwr_n, "R1 reset state",
        {bus_req, mst_oe, shr_oe, mrd_n, mwr_n}, 5'b00011);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10: burst before any configuration
    burst(0, 2, 16'h0100, 0, 0, 1);
    // R2: zero-length request ignored
    @(negedge clk); svc_req = 1; svc_len = 0; svc_wr = 1;
    @(negedge clk); svc_req = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!bus_req && mwr_n, "R2 zero length ignored", bus_req, 0);
    end
    // R9 port mode, directed waits
    cfg(0);
    burst(1, 3, 16'h2000, 1, 0, 2);
    burst(0, 2, 16'hFFFF, 2, 0, 3);
    // R12 config write mid-burst ignored
    burst(1, 4, 16'h0040, 0, 1, 4);
    // R8 long address mode
    cfg(1);
    burst(0, 1, 16'h0007, 1, 0, 5);
    burst(1, 5, 16'hFFFD, 2, 1, 6);
    for (int b = 0; b < 20; b++) begin
      upper_addr = $urandom;
      burst($urandom % 2, 1 + ($urandom % 12), $urandom, 0, 0, 7 + b);
      if (b == 9) cfg(0);
    end
    repeat (3) @(negedge clk);
    summary();
  end
endmodule